// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial front end of a two-wire memory device. It takes in write bytes and gathers them into a page buffer. When the transfer ends, it copies the gathered bytes into the memory array during an internal write cycle of fixed length. The front end starts a transaction by loading a start address. It then presents data bytes one at a time and ends with a commit pulse on the stop condition.

Each byte lands at the in-page offset held by the current address counter, and only the low offset bits advance. A page of 2^PAGE_W bytes therefore wraps onto itself, and a later byte replaces an earlier one at the same offset. After the commit, the block stays busy for exactly WC_CYCLES clocks. During that time the front end refuses the acknowledge of address words, which is how a controller polls for completion. All transaction inputs are ignored while the block is busy.

During the first 2^PAGE_W busy clocks the block walks the page offsets in ascending order. It issues one array write for each offset that received a byte, unless the write-protect input is high and the page lies in the top eighth of the array. A commit with nothing buffered writes nothing and does not raise busy. A start condition before the commit does the same.

Top module: `page_write_buffer`

## Requirements
- R1: After reset busy_o is 0, mem_we_o is 0 and cur_addr_o is 0.
- R2: An address load sets cur_addr_o to addr_i on the next clock. Each accepted byte is stored at offset cur_addr_o[PAGE_W-1:0] and then increments only those low bits, leaving cur_addr_o[ADDR_W-1:PAGE_W] unchanged.
- R3: After offset 2^PAGE_W-1 the offset returns to 0. A byte sent to an offset that already holds one replaces it, and only the newest value reaches the array.
- R4: A commit with 1 to 2^PAGE_W buffered offsets raises busy_o on the next clock and holds it high for exactly WC_CYCLES clocks. In busy clock j (j counted from 0, j < 2^PAGE_W), mem_we_o is 1 exactly when offset j was filled. The write then goes to address {page, j} with the buffered byte.
- R5: The transaction is dropped and busy_o stays 0 in three cases: a commit when no byte was buffered, a start_i pulse before the commit, and bytes or a commit sent with no address load since the last transaction. No array write follows in any of these cases.
- R6: While busy_o is 1, addr_load_i, byte_valid_i, commit_i and start_i have no effect. cur_addr_o stays unchanged, the buffer is untouched and busy ends on time.
- R7: While wp_i is 1, no array write is issued to an address whose top three bits are all 1. While wp_i is 0, such writes proceed. Addresses below the top eighth are never blocked.
- R8: mem_we_o is 1 only while busy_o is 1, and mem_addr_o then lies in the page of cur_addr_o.
- R9: After the commit, cur_addr_o holds the address that follows the last byte, wrapped within the page and never carried into the next page.
- R10: When inputs arrive in the same clock, the priority is start_i, then commit_i, then addr_load_i, then byte_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load a start address and open a transaction |
| addr_i | input | ADDR_W | Start address |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Stop condition; begins the write cycle |
| start_i | input | 1 | Start condition; drops an open transaction |
| wp_i | input | 1 | Write protect for the top eighth of the array |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Internal write cycle in progress |
| cur_addr_o | output | ADDR_W | Current address counter |

## Verification
The hardest case to reach from the ports is a page that wraps and overwrites itself. For this, more bytes must be sent than the page holds, starting from a non-zero offset. Only then do some offsets receive two values, and only the newer one may reach the array. The bench sends 70 bytes from offset 10 and, separately, 8 bytes from offset 60. A reference model follows the in-page offset on every clock and checks that each write carries the last byte stored at that offset. The bench also pulses every transaction input during a busy window and then checks that the address counter and the count of array writes are unchanged.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_BUSY = 2'd2
  } pwb_state_e;
endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (step_i) addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6,
  localparam int DEPTH = 1 << PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_o
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) data_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (wr_i)  vld_q[wr_idx_i] <= 1'b1;
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_o     = |vld_q;
endmodule

// File: rtl/pwb_commit_timer.sv
module pwb_commit_timer #(
  parameter int PAGE_W    = 6,
  parameter int WC_CYCLES = 1000,
  localparam int DEPTH = 1 << PAGE_W,
  localparam int EL_W  = (($clog2(WC_CYCLES) > PAGE_W) ? $clog2(WC_CYCLES) : PAGE_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic              last_o,
  output logic              slot_vld_o,
  output logic [PAGE_W-1:0] slot_o
);
  logic [EL_W-1:0] el_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     el_q <= '0;
    else if (!run_i) el_q <= '0;
    else             el_q <= el_q + 1'b1;
  end

  assign last_o     = run_i && (32'(el_q) == WC_CYCLES - 1);
  assign slot_vld_o = run_i && (32'(el_q) < DEPTH);
  assign slot_o     = el_q[PAGE_W-1:0];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 15,
  parameter int PAGE_W    = 6,
  parameter int WC_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              start_i,
  input  logic              wp_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  localparam int PROT_W = 3;

  pwb_state_e state_q, state_d;
  logic buf_clr, buf_wr, ctr_load, any_vld, rd_vld;
  logic t_last, slot_vld;
  logic [PAGE_W-1:0] slot;
  logic [DATA_W-1:0] rd_data;
  logic accept, prot_hit;

  assign accept = (state_q != ST_BUSY);

  // priority: start > commit > load > byte (R10)
  always_comb begin
    state_d  = state_q;
    buf_clr  = 1'b0;
    buf_wr   = 1'b0;
    ctr_load = 1'b0;
    if (!accept) begin
      if (t_last) begin
        state_d = ST_IDLE;
        buf_clr = 1'b1;
      end
    end else if (start_i) begin
      state_d = ST_IDLE;
      buf_clr = 1'b1;
    end else if (commit_i) begin
      if (state_q == ST_FILL && any_vld) begin
        state_d = ST_BUSY;
      end else begin
        state_d = ST_IDLE;
        buf_clr = 1'b1;
      end
    end else if (addr_load_i) begin
      state_d  = ST_FILL;
      buf_clr  = 1'b1;
      ctr_load = 1'b1;
    end else if (byte_valid_i && state_q == ST_FILL) begin
      buf_wr = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  pwb_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_addr_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_addr_i(addr_i),
    .step_i     (buf_wr),
    .addr_o     (cur_addr_o)
  );

  pwb_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) i_page_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (buf_clr),
    .wr_i     (buf_wr),
    .wr_idx_i (cur_addr_o[PAGE_W-1:0]),
    .wr_data_i(byte_i),
    .rd_idx_i (slot),
    .rd_data_o(rd_data),
    .rd_vld_o (rd_vld),
    .any_o    (any_vld)
  );

  pwb_commit_timer #(.PAGE_W(PAGE_W), .WC_CYCLES(WC_CYCLES)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (!accept),
    .last_o    (t_last),
    .slot_vld_o(slot_vld),
    .slot_o    (slot)
  );

  // protection is not latched: wp_i acts on each write
  assign prot_hit   = wp_i && (&cur_addr_o[ADDR_W-1 -: PROT_W]);
  assign mem_we_o   = slot_vld && rd_vld && !prot_hit;
  assign mem_addr_o = {cur_addr_o[ADDR_W-1:PAGE_W], slot};
  assign mem_data_o = rd_data;
  assign busy_o     = !accept;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int ADDR_W    = 15,
  parameter int PAGE_W    = 6,
  parameter int WC_CYCLES = 1000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] cur_addr_o
);
  logic [31:0] blen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     blen_q <= '0;
    else if (busy_o) blen_q <= blen_q + 1;
    else             blen_q <= '0;
  end

  // R8
  we_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  // R8
  we_in_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[ADDR_W-1:PAGE_W] == cur_addr_o[ADDR_W-1:PAGE_W]);

  // R7
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && wp_i) |-> !(&mem_addr_o[ADDR_W-1 -: 3]));

  // R6
  hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cur_addr_o));

  // R4
  rise_after_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_i));

  // R4
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> blen_q == WC_CYCLES);

  // R4
  ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o) && $past(busy_o)) |->
      mem_addr_o[PAGE_W-1:0] > $past(mem_addr_o[PAGE_W-1:0]));
endmodule

bind page_write_buffer pwb_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WC_CYCLES(WC_CYCLES)
) i_pwb_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .commit_i  (commit_i),
  .wp_i      (wp_i),
  .busy_o    (busy_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .cur_addr_o(cur_addr_o)
);

// File: tb/test_page_write_buffer.sv
module test_page_write_buffer;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int AW = 15;
  localparam int PW = 6;
  localparam int WC = 80;
  localparam int PG = 1 << PW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic addr_load_i = 0, byte_valid_i = 0, commit_i = 0, start_i = 0, wp_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] byte_i = '0;
  logic mem_we_o, busy_o;
  logic [AW-1:0] mem_addr_o, cur_addr_o;
  logic [DW-1:0] mem_data_o;

  page_write_buffer #(.DATA_W(DW), .ADDR_W(AW), .PAGE_W(PW), .WC_CYCLES(WC)) i_page_write_buffer (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .commit_i(commit_i), .start_i(start_i),
    .wp_i(wp_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .busy_o(busy_o), .cur_addr_o(cur_addr_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  int total = 0, bad = 0, cycles = 0, nwr = 0;
  string req = "R1";
  int obs_mem [int];

  // reference model: 0 idle, 1 filling, 2 busy
  int m_mode = 0, m_cur = 0, m_el = 0;
  int m_data [PG];
  bit m_vld [PG];

  task automatic chk(bit ok, string r, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic void m_clear();
    for (int i = 0; i < PG; i++) m_vld[i] = 0;
  endfunction

  function automatic bit m_any();
    for (int i = 0; i < PG; i++) if (m_vld[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_cur = 0; m_el = 0; m_clear();
    end else if (m_mode == 2) begin
      if (m_el == WC - 1) begin m_mode = 0; m_el = 0; m_clear(); end
      else m_el++;
    end else if (start_i) begin
      m_mode = 0; m_clear();
    end else if (commit_i) begin
      if (m_mode == 1 && m_any()) begin m_mode = 2; m_el = 0; end
      else begin m_mode = 0; m_clear(); end
    end else if (addr_load_i) begin
      m_mode = 1; m_cur = int'(addr_i); m_clear();
    end else if (byte_valid_i && m_mode == 1) begin
      m_data[m_cur % PG] = int'(byte_i);
      m_vld[m_cur % PG] = 1;
      m_cur = (m_cur & ~(PG - 1)) | ((m_cur + 1) & (PG - 1));
    end
  end

  // compare every clock, a quarter period after the edge
  always @(posedge clk_i) begin
    #(CLK_P/4);
    cycles++;
    if (rst_ni) begin
      bit e_busy, e_we;
      int e_addr;
      e_busy = (m_mode == 2);
      e_addr = (m_cur & ~(PG - 1)) | (m_el % PG);
      e_we = e_busy && m_el < PG && m_vld[m_el % PG] &&
             !(wp_i && ((m_cur >> (AW - 3)) == 7));
      chk(busy_o == e_busy, req, "busy", int'(busy_o), int'(e_busy));
      chk(int'(cur_addr_o) == m_cur, req, "cur_addr", int'(cur_addr_o), m_cur);
      chk(mem_we_o == e_we, req, "mem_we", int'(mem_we_o), int'(e_we));
      if (e_we && mem_we_o) begin
        chk(int'(mem_addr_o) == e_addr, req, "mem_addr", int'(mem_addr_o), e_addr);
        chk(int'(mem_data_o) == m_data[m_el % PG], req, "mem_data",
            int'(mem_data_o), m_data[m_el % PG]);
      end
      if (mem_we_o) begin
        obs_mem[int'(mem_addr_o)] = int'(mem_data_o);
        nwr++;
      end
    end
  end

  task automatic pulse_load(int a);
    @(negedge clk_i); addr_load_i = 1; addr_i = AW'(a);
    @(negedge clk_i); addr_load_i = 0;
  endtask
  task automatic pulse_byte(int d);
    @(negedge clk_i); byte_valid_i = 1; byte_i = DW'(d);
    @(negedge clk_i); byte_valid_i = 0;
  endtask
  task automatic pulse_commit();
    @(negedge clk_i); commit_i = 1;
    @(negedge clk_i); commit_i = 0;
  endtask
  task automatic pulse_start();
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, req, "watchdog", cycles, 0);
    finish_run();
  end

  initial begin
    idle(3);
    // R1: reset state
    chk(busy_o == 0 && mem_we_o == 0 && cur_addr_o == 0, "R1", "reset",
        int'({busy_o, mem_we_o, cur_addr_o}), 0);
    rst_ni = 1;
    idle(2);

    // R2 / R4: three bytes from offset 5
    req = "R2"; nwr = 0;
    pulse_load('h0105);
    chk(cur_addr_o == 'h0105, "R2", "load", int'(cur_addr_o), 'h0105);
    pulse_byte('hA1); pulse_byte('hA2); pulse_byte('hA3);
    req = "R4"; pulse_commit(); idle(WC + 4);
    chk(nwr == 3, "R4", "write count", nwr, 3);
    chk(obs_mem['h0105] == 'hA1, "R4", "data 105", obs_mem['h0105], 'hA1);
    chk(cur_addr_o == 'h0108, "R9", "after commit", int'(cur_addr_o), 'h0108);

    // R3 / R9: wrap from offset 60
    req = "R3"; nwr = 0;
    pulse_load('h023C);
    for (int i = 0; i < 8; i++) pulse_byte('h10 + i);
    pulse_commit(); idle(WC + 4);
    chk(nwr == 8, "R3", "wrap count", nwr, 8);
    chk(obs_mem['h0200] == 'h14, "R3", "wrap data", obs_mem['h0200], 'h14);
    chk(cur_addr_o == 'h0204, "R9", "wrap addr", int'(cur_addr_o), 'h0204);

    // R3: 70 bytes from offset 10 overwrite offsets 10..15
    nwr = 0;
    pulse_load('h030A);
    for (int i = 0; i < 70; i++) pulse_byte(i);
    pulse_commit(); idle(WC + 4);
    chk(nwr == PG, "R3", "overwrite count", nwr, PG);
    chk(obs_mem['h030A] == 64, "R3", "overwrite data", obs_mem['h030A], 64);
    chk(cur_addr_o == 'h0310, "R9", "overwrite addr", int'(cur_addr_o), 'h0310);

    // R4: full page from offset 0
    req = "R4"; nwr = 0;
    pulse_load('h0500);
    for (int i = 0; i < PG; i++) pulse_byte('hC0 ^ i);
    pulse_commit(); idle(WC + 4);
    chk(nwr == PG, "R4", "full page count", nwr, PG);
    chk(cur_addr_o == 'h0500, "R9", "full page addr", int'(cur_addr_o), 'h0500);

    // R5: cancellations
    req = "R5"; nwr = 0;
    pulse_load('h0600); pulse_commit(); idle(3);
    chk(busy_o == 0, "R5", "empty commit", int'(busy_o), 0);
    pulse_load('h0610); pulse_byte('h55); pulse_start(); pulse_commit(); idle(3);
    chk(busy_o == 0, "R5", "start cancel", int'(busy_o), 0);
    pulse_byte('h66); pulse_byte('h67); pulse_commit(); idle(3);
    chk(busy_o == 0, "R5", "idle bytes", int'(busy_o), 0);
    chk(cur_addr_o == 'h0611, "R5", "idle bytes addr", int'(cur_addr_o), 'h0611);
    chk(nwr == 0, "R5", "no writes", nwr, 0);

    // R10: start beats commit in the same clock
    req = "R10";
    pulse_load('h0700); pulse_byte('h01);
    @(negedge clk_i); start_i = 1; commit_i = 1;
    @(negedge clk_i); start_i = 0; commit_i = 0;
    idle(2);
    chk(busy_o == 0 && nwr == 0, "R10", "start over commit", int'(busy_o), 0);

    // R6: inputs ignored while busy
    req = "R6"; nwr = 0;
    pulse_load('h0800); pulse_byte('h77); pulse_commit();
    pulse_load('h0123); pulse_byte('h99); pulse_start(); pulse_commit();
    chk(cur_addr_o == 'h0801, "R6", "addr held", int'(cur_addr_o), 'h0801);
    idle(WC + 4);
    pulse_byte('h98); idle(2);
    chk(nwr == 1 && busy_o == 0, "R6", "single write", nwr, 1);
    chk(cur_addr_o == 'h0801, "R6", "addr after", int'(cur_addr_o), 'h0801);

    // R7: write protect
    req = "R7"; nwr = 0; wp_i = 1;
    pulse_load('h7F05); pulse_byte('h11); pulse_byte('h12);
    pulse_commit(); idle(WC + 4);
    chk(nwr == 0, "R7", "protected top", nwr, 0);
    pulse_load('h0400); pulse_byte('h21); pulse_commit(); idle(WC + 4);
    chk(nwr == 1, "R7", "low region", nwr, 1);
    wp_i = 0; nwr = 0;
    pulse_load('h7F05); pulse_byte('h31); pulse_byte('h32);
    pulse_commit(); idle(WC + 4);
    chk(nwr == 2, "R7", "unprotected top", nwr, 2);
    chk(obs_mem['h7F06] == 'h32, "R8", "top data", obs_mem['h7F06], 'h32);

    finish_run();
  end
endmodule